// File: doc/BRIEF.md
# Line Stream Formatter with Audio Payload

This block turns one line of picture samples plus a handful of buffered sound samples into a single serial word stream. Each line follows the same pattern. A four-word start marker comes first, and its last word flags picture data and carries the field identifier. Exactly 720 picture words follow. Next comes a four-word end marker, whose last word flags sound data and states how many sound words come after it. Those sound words follow, and the next start marker begins on the clock after the last of them.

Payload words are clamped, so no picture or sound word can match a reserved marker value. The downstream parser can therefore resync on markers alone. The block pulls picture words with a read strobe, one per clock, and they never stall. Sound words arrive over a ready/valid handshake. A missing sound word causes a one-clock gap on the output (`o_vld` low) and affects nothing else. The default word width is 8 bits, and a 10-bit build (`DW=10`) is also supported.

Top module: `fmt601_stream`

## Requirements
- R1: While `rst_n` is low, `o_vld`, `vid_rd` and `aud_rdy` are all 0. The first word after reset is the first word of a start marker.
- R2: A start marker is the four words all-ones, 0, 0, and then a flag word. In 8-bit form the flag word has bit 7 = 1, bit 6 = `fid` (sampled as that word is formed) and bits 5..0 = 0.
- R3: After the start marker come exactly 720 picture words, on consecutive clocks with `o_vld` high throughout.
- R4: An end marker is all-ones, 0, 0, and then a flag word. In 8-bit form the flag word has bit 7 = 1, bit 6 = 0 and bits 5..0 = the sound count.
- R5: The sound count is `aud_len` saturated at 63, sampled as the end flag word is formed. Exactly that many sound words follow the end marker.
- R6: With a count of 0, the start marker follows the end marker directly. Otherwise it begins on the clock after the last sound word.
- R7: In 8-bit form, a payload word of 0x00 becomes 0x01, 0xFF becomes 0xFE, and every other value passes through unchanged.
- R8: In 10-bit form, payload words 0..3 become 4 and 1020..1023 become 1019. The markers use 0x3FF, 0, 0, and the flag word is the 8-bit flag word shifted left by two.
- R9: A sound word is taken only on a clock with `aud_vld` and `aud_rdy` both high. A sound-segment clock without `aud_vld` gives `o_vld` = 0 on the next clock and holds `o_data`. Marker and picture words never stall.
- R10: `vid_rd` is high exactly on the clocks that consume a picture word. `vid_rd` and `aud_rdy` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fid | input | 1 | Field identifier for the coming line |
| vid_data | input | DW | Picture word, consumed when `vid_rd` is high |
| vid_rd | output | 1 | Picture word consumed this clock |
| aud_len | input | LEN_W | Requested sound word count |
| aud_data | input | DW | Sound word |
| aud_vld | input | 1 | Sound word valid |
| aud_rdy | output | 1 | Block is in its sound segment and will take a word |
| o_data | output | DW | Output stream word |
| o_vld | output | 1 | `o_data` holds a new word |

## Verification
The assertions assume three things about the inputs. A picture word is always available when `vid_rd` is high. `aud_data` holds steady while `aud_vld` is high and no transfer has taken place. `aud_len` and `fid` are stable around the clocks where they are sampled. The bench meets these assumptions in the following ways:
- Picture and sound words come from counters that advance only on a completed transfer.
- The valid signal toggles or stays high on falling edges.
- Count and field inputs change only after a line's last word has been read.

// File: rtl/fmt601_stream.sv
module fmt601_stream #(
  parameter int DW    = 8,
  parameter int VID_N = 720,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fid,
  input  logic [DW-1:0]    vid_data,
  output logic             vid_rd,
  input  logic [LEN_W-1:0] aud_len,
  input  logic [DW-1:0]    aud_data,
  input  logic             aud_vld,
  output logic             aud_rdy,
  output logic [DW-1:0]    o_data,
  output logic             o_vld
);
  localparam int CNT_W   = 6;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int PAD     = DW - 8;
  localparam int LO      = 1 << PAD;
  localparam int HI      = (1 << DW) - 1 - LO;
  localparam int IDX_W   = $clog2(VID_N);

  typedef enum logic [1:0] {S_SAV, S_VID, S_EAV, S_AUD} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt_q;
  logic             pay_q;
  logic [CNT_W-1:0] len_c;
  logic [DW-1:0]    sav4, eav4, word_c;
  logic             adv;

  function automatic logic [DW-1:0] clamp(input logic [DW-1:0] v);
    if (v < DW'(LO)) return DW'(LO);
    if (v > DW'(HI)) return DW'(HI);
    return v;
  endfunction

  function automatic logic [DW-1:0] mark(input logic [IDX_W-1:0] i, input logic [DW-1:0] flag);
    if (i == '0) return '1;
    if (i == IDX_W'(3)) return flag;
    return '0;
  endfunction

  assign len_c   = (aud_len > LEN_W'(CNT_MAX)) ? CNT_W'(CNT_MAX) : aud_len[CNT_W-1:0];
  assign sav4    = DW'({1'b1, fid, 6'b0}) << PAD;
  assign eav4    = DW'({2'b10, len_c}) << PAD;
  assign vid_rd  = (st == S_VID);
  assign aud_rdy = (st == S_AUD);
  assign adv     = (st != S_AUD) || aud_vld;

  always_comb begin
    case (st)
      S_SAV:   word_c = mark(idx, sav4);
      S_VID:   word_c = clamp(vid_data);
      S_EAV:   word_c = mark(idx, eav4);
      default: word_c = clamp(aud_data);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_SAV;
      idx    <= '0;
      cnt_q  <= '0;
      pay_q  <= 1'b0;
      o_vld  <= 1'b0;
      o_data <= '0;
    end else begin
      o_vld <= adv;
      if (adv) begin
        o_data <= word_c;
        pay_q  <= (st == S_VID) || (st == S_AUD);
        idx    <= idx + 1'b1;
        case (st)
          S_SAV: if (idx == IDX_W'(3)) begin
            st  <= S_VID;
            idx <= '0;
          end
          S_VID: if (idx == IDX_W'(VID_N - 1)) begin
            st  <= S_EAV;
            idx <= '0;
          end
          S_EAV: if (idx == IDX_W'(3)) begin
            cnt_q <= len_c;
            st    <= (len_c == '0) ? S_SAV : S_AUD;
            idx   <= '0;
          end
          default: if ((idx + 1'b1) == IDX_W'(cnt_q)) begin
            st  <= S_SAV;
            idx <= '0;
          end
        endcase
      end
    end
  end

  a_r7_payload_range: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && pay_q) |-> (o_data >= DW'(LO) && o_data <= DW'(HI)));

  a_r9_stall_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (aud_rdy && !aud_vld) |=> (!o_vld && $stable(o_data)));

  a_r3_video_flow: assert property (@(posedge clk) disable iff (!rst_n)
    vid_rd |=> o_vld);

  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vid_rd, aud_rdy}));

  a_r5_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    aud_rdy |-> (cnt_q != '0));
endmodule

// File: tb/sim_fmt601_stream.sv
module sim_fmt601_stream;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, fid = 1'b0, stall_mode = 1'b0, aud_vld = 1'b0;
  logic [7:0] aud_len = 8'd0;
  logic [7:0] vid_data, aud_data, o_data;
  logic       vid_rd, aud_rdy, o_vld;
  logic [9:0] vid_data1, o_data1;
  logic       vid_rd1, aud_rdy1, o_vld1;
  int vcnt = 0, acnt = 0, vcnt1 = 0;
  int nchk = 0, nfail = 0;

  fmt601_stream u0 (.clk(clk), .rst_n(rst_n), .fid(fid), .vid_data(vid_data), .vid_rd(vid_rd),
    .aud_len(aud_len), .aud_data(aud_data), .aud_vld(aud_vld), .aud_rdy(aud_rdy),
    .o_data(o_data), .o_vld(o_vld));

  fmt601_stream #(.DW(10)) u1 (.clk(clk), .rst_n(rst_n), .fid(fid), .vid_data(vid_data1),
    .vid_rd(vid_rd1), .aud_len(8'd0), .aud_data(10'd0), .aud_vld(1'b1), .aud_rdy(aud_rdy1),
    .o_data(o_data1), .o_vld(o_vld1));

  function automatic int vpat(int n); return n % 256; endfunction
  function automatic int vpat10(int n); return (1016 + n) % 1024; endfunction
  function automatic int apat(int n);
    case (n % 4) 0: return 255; 1: return 0; default: return (n * 3) % 256; endcase
  endfunction
  function automatic int clip8(int v); return v == 0 ? 1 : (v == 255 ? 254 : v); endfunction
  function automatic int clip10(int v); return v < 4 ? 4 : (v > 1019 ? 1019 : v); endfunction

  assign vid_data  = 8'(vpat(vcnt));
  assign aud_data  = 8'(apat(acnt));
  assign vid_data1 = 10'(vpat10(vcnt1));
  always @(posedge clk) begin
    if (vid_rd) vcnt <= vcnt + 1;
    if (vid_rd1) vcnt1 <= vcnt1 + 1;
    if (aud_vld && aud_rdy) acnt <= acnt + 1;
  end

  initial forever begin
    @(negedge clk);
    aud_vld = stall_mode ? ~aud_vld : 1'b1;
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(output int b, inout int gaps);
    @(negedge clk);
    while (!o_vld) begin gaps++; @(negedge clk); end
    b = o_data;
  endtask

  // stimulus vectors: [15:10] expected count, [9] fid, [8] stall, [7:0] aud_len
  localparam logic [15:0] VEC [6] = '{
    {6'd5,  1'b0, 1'b0, 8'd5},
    {6'd0,  1'b1, 1'b0, 8'd0},
    {6'd63, 1'b0, 1'b0, 8'd63},
    {6'd63, 1'b1, 1'b1, 8'd200},
    {6'd1,  1'b0, 1'b1, 8'd1},
    {6'd63, 1'b1, 1'b0, 8'd64}
  };

  int ev = 0, ea = 0;

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : u1_check
    @(posedge rst_n);
    for (int k = 0; k < 724; k++) begin
      @(negedge clk);
      chk("R8 10-bit valid", int'(o_vld1), 1);
      if (k == 0) chk("R8 10-bit mark0", int'(o_data1), 1023);
      else if (k < 3) chk("R8 10-bit mark zero", int'(o_data1), 0);
      else if (k == 3) chk("R8 10-bit flag", int'(o_data1), 512);
      else chk("R8 10-bit clamp", int'(o_data1), clip10(vpat10(k - 4)));
    end
  end

  initial begin
    int b, g, ag;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    chk("R1 reset o_vld", int'(o_vld), 0);
    chk("R1 reset vid_rd", int'(vid_rd), 0);
    chk("R1 reset aud_rdy", int'(aud_rdy), 0);
    rst_n = 1'b1;
    for (int L = 0; L < 6; L++) begin
      v = VEC[L];
      fid = v[9]; stall_mode = v[8]; aud_len = v[7:0];
      g = 0; ag = 0;
      rd(b, g); chk("R2 R6 start mark0", b, 255);
      rd(b, g); chk("R2 start mark1", b, 0);
      rd(b, g); chk("R2 start mark2", b, 0);
      rd(b, g); chk("R2 start flag", b, 128 + 64 * int'(v[9]));
      for (int k = 0; k < 720; k++) begin
        rd(b, g); chk("R3 R7 R10 video word", b, clip8(vpat(ev))); ev++;
      end
      rd(b, g); chk("R4 end mark0", b, 255);
      rd(b, g); chk("R4 end mark1", b, 0);
      rd(b, g); chk("R4 end mark2", b, 0);
      rd(b, g); chk("R4 R5 end flag", b, 128 + int'(v[15:10]));
      chk("R3 R9 no gaps before audio", g, 0);
      for (int k = 0; k < int'(v[15:10]); k++) begin
        rd(b, ag); chk("R5 R7 R9 audio word", b, clip8(apat(ea))); ea++;
      end
      if (v[8] && v[15:10] > 1) chk("R9 stall gaps seen", int'(ag > 0), 1);
      if (!v[8]) chk("R9 no gaps unstalled", ag, 0);
    end
    stall_mode = 1'b0;
    g = 0;
    rd(b, g); chk("R6 start after last audio", b, 255);
    chk("R6 no gap at line end", g, 0);
    repeat (100) @(negedge clk);
    chk("R10 vid_rd mid line", int'(vid_rd), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset o_vld", int'(o_vld), 0);
    chk("R1 mid reset vid_rd", int'(vid_rd), 0);
    chk("R1 mid reset aud_rdy", int'(aud_rdy), 0);
    fid = 1'b1;
    rst_n = 1'b1;
    rd(b, g); chk("R1 first word after reset", b, 255);
    rd(b, g); chk("R1 R2 mark1 after reset", b, 0);
    rd(b, g); chk("R1 R2 mark2 after reset", b, 0);
    rd(b, g); chk("R1 R2 flag after reset", b, 192);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule